// File: doc/BRIEF.md
# Constant Off-Time Current Chopper

This block keeps the current in a bridge load under control by chopping the drive. Each clock it compares a digital load-current sample (unsigned, in mA) with a limit. When the sample rises above the limit, the block masks the external PWM command for a fixed number of clock cycles. After that window it lets the command through again. While the drive is masked, further current samples are ignored. This yields constant off-time regulation. The device can ride through a heavy load for a short while without a shutdown.

The limit depends on a digital junction-temperature sample (unsigned, in °C). Above the hot level (default 160 °C) the limit drops from the nominal value to a reduced value (default 4200 mA). Hot mode is left only once the temperature has fallen more than a configurable hysteresis below that level. A second, higher level (default 175 °C) is compared separately. Crossing it sends a one-cycle latch-off request to the fault logic elsewhere in the chip. This block does not hold the latch itself.

Top module: `chop_limiter`

## Requirements
- R1: While rst_ni is low, chop_o and ot_fault_o are 0 and drv_en_o equals pwm_i.
- R2: While chop_o is 0, drv_en_o equals pwm_i in the same cycle.
- R3: A current sample strictly greater than the active limit, taken while chop_o is 0, raises chop_o at the next clock edge. chop_o then stays 1 for exactly OFF_CYC cycles, and drv_en_o is 0 for all of those cycles.
- R4: Current samples taken while chop_o is 1 neither extend nor restart the off window.
- R5: If the sample is still above the limit in the first cycle after the window ends, drv_en_o follows pwm_i for that one cycle. A new window then starts at the next edge.
- R6: Out of hot mode, the limit is LIM_NOM (default 5000 mA), and a sample equal to the limit does not trip.
- R7: A temperature sample above HOT_C enters hot mode at the next edge, and from then on the limit is LIM_HOT (default 4200 mA). A current sample taken in the same cycle as the first hot temperature is still judged against the nominal limit.
- R8: Hot mode is left only on a temperature sample below HOT_C - HYST_C (default 155). Samples from HOT_C - HYST_C up to HOT_C keep the current mode.
- R9: ot_fault_o pulses high for one cycle, one edge after the first temperature sample above SHUT_C. It does not pulse again until a sample at or below SHUT_C has been seen.
- R10: The over-temperature request and the start of an off window are independent, so both can rise at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | External PWM drive command |
| cur_i | input | CUR_W | Load current sample, mA |
| temp_i | input | TEMP_W | Junction temperature sample, °C |
| drv_en_o | output | 1 | Gated bridge drive enable |
| chop_o | output | 1 | Off window active |
| ot_fault_o | output | 1 | One-cycle over-temperature latch-off request |

## Verification
Two coincidences are provoked. In the first, a temperature sample that enters hot mode arrives in the same cycle as a current sample that lies between the reduced and nominal limits. The bench expects no trip at that edge and a trip at the following edge, because the limit in force is the one registered before the sample. In the second, a temperature sample above the shutdown level arrives together with an over-limit current sample. The bench expects both ot_fault_o and chop_o to rise at the same edge, with the window length unaffected. Temperature sweeps in both directions through the hysteresis band are judged with a mode model kept in the bench.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic {
    MODE_NOM = 1'b0,
    MODE_HOT = 1'b1
  } lim_mode_e;
endpackage

// File: rtl/chop_thr_sel.sv
module chop_thr_sel
  import chop_pkg::*;
#(
  parameter int CUR_W   = 14,
  parameter int TEMP_W  = 8,
  parameter int LIM_NOM = 5000,
  parameter int LIM_HOT = 4200,
  parameter int HOT_C   = 160,
  parameter int HYST_C  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  output logic [CUR_W-1:0]  thr_o
);
  localparam logic [TEMP_W-1:0] HOT_T  = TEMP_W'(HOT_C);
  localparam logic [TEMP_W-1:0] COOL_T = TEMP_W'(HOT_C - HYST_C);

  lim_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               mode_q <= MODE_NOM;
    else if (temp_i > HOT_T)   mode_q <= MODE_HOT;
    else if (temp_i < COOL_T)  mode_q <= MODE_NOM;
  end

  assign thr_o = (mode_q == MODE_HOT) ? CUR_W'(LIM_HOT) : CUR_W'(LIM_NOM);
endmodule

// File: rtl/chop_off_timer.sv
module chop_off_timer #(
  parameter int OFF_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic over_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(OFF_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  // over_i is only looked at once the window has drained
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (busy_o)           cnt_q <= cnt_q - 1'b1;
    else if (over_i)           cnt_q <= CNT_W'(OFF_CYC);
  end
endmodule

// File: rtl/chop_ot_det.sv
module chop_ot_det #(
  parameter int TEMP_W = 8,
  parameter int SHUT_C = 175
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              fault_o
);
  localparam logic [TEMP_W-1:0] SHUT_T = TEMP_W'(SHUT_C);

  logic above;
  logic above_q;
  logic fault_q;

  assign above = temp_i > SHUT_T;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      above_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      above_q <= above;
      fault_q <= above & ~above_q;
    end
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/chop_limiter.sv
module chop_limiter #(
  parameter int CUR_W   = 14,
  parameter int TEMP_W  = 8,
  parameter int LIM_NOM = 5000,
  parameter int LIM_HOT = 4200,
  parameter int HOT_C   = 160,
  parameter int HYST_C  = 5,
  parameter int SHUT_C  = 175,
  parameter int OFF_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwm_i,
  input  logic [CUR_W-1:0]  cur_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              drv_en_o,
  output logic              chop_o,
  output logic              ot_fault_o
);
  logic [CUR_W-1:0] thr;
  logic             over;
  logic             busy;

  chop_thr_sel #(
    .CUR_W(CUR_W), .TEMP_W(TEMP_W), .LIM_NOM(LIM_NOM),
    .LIM_HOT(LIM_HOT), .HOT_C(HOT_C), .HYST_C(HYST_C)
  ) u_thr (
    .clk_i(clk_i), .rst_ni(rst_ni), .temp_i(temp_i), .thr_o(thr)
  );

  assign over = cur_i > thr;

  chop_off_timer #(.OFF_CYC(OFF_CYC)) u_off (
    .clk_i(clk_i), .rst_ni(rst_ni), .over_i(over), .busy_o(busy)
  );

  chop_ot_det #(.TEMP_W(TEMP_W), .SHUT_C(SHUT_C)) u_ot (
    .clk_i(clk_i), .rst_ni(rst_ni), .temp_i(temp_i), .fault_o(ot_fault_o)
  );

  assign chop_o   = busy;
  assign drv_en_o = pwm_i & ~busy;
endmodule

// File: rtl/chop_limiter_chk.sv
module chop_limiter_chk #(
  parameter int CUR_W   = 14,
  parameter int TEMP_W  = 8,
  parameter int SHUT_C  = 175,
  parameter int OFF_CYC = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwm_i,
  input logic [CUR_W-1:0]  cur_i,
  input logic [TEMP_W-1:0] temp_i,
  input logic [CUR_W-1:0]  thr,
  input logic              drv_en_o,
  input logic              chop_o,
  input logic              ot_fault_o
);
  localparam int RUN_W = $clog2(OFF_CYC + 2) + 1;

  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_len <= '0;
    else if (chop_o) run_len <= run_len + 1'b1;
    else             run_len <= '0;
  end

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!chop_o && !ot_fault_o);
    end
  end

  // R2
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chop_o |-> drv_en_o == pwm_i);

  // R3
  drive_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chop_o |-> !drv_en_o);

  // R3
  trip_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chop_o && cur_i > thr) |=> chop_o);

  // R4
  window_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(chop_o) |-> run_len == RUN_W'(OFF_CYC));

  // R9
  fault_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_fault_o |=> !ot_fault_o);

  // R9
  fault_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ot_fault_o) |-> $past(temp_i) > TEMP_W'(SHUT_C));
endmodule

bind chop_limiter chop_limiter_chk #(
  .CUR_W(CUR_W), .TEMP_W(TEMP_W), .SHUT_C(SHUT_C), .OFF_CYC(OFF_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwm_i(pwm_i), .cur_i(cur_i),
  .temp_i(temp_i), .thr(thr), .drv_en_o(drv_en_o), .chop_o(chop_o),
  .ot_fault_o(ot_fault_o)
);

// File: tb/sim_chop_limiter.sv
module sim_chop_limiter;
  localparam int CUR_W = 14, TEMP_W = 8, OFF = 5;
  localparam int NOM = 5000, HOT = 4200, HOT_C = 160, HYST = 5, SHUT = 175;

  logic clk = 1'b0, rst_ni = 1'b0, pwm = 1'b1;
  logic [CUR_W-1:0] cur = '0;
  logic [TEMP_W-1:0] temp = 8'd25;
  logic drv_en, chop, fault;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chop_limiter #(.CUR_W(CUR_W), .TEMP_W(TEMP_W), .LIM_NOM(NOM), .LIM_HOT(HOT),
    .HOT_C(HOT_C), .HYST_C(HYST), .SHUT_C(SHUT), .OFF_CYC(OFF)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pwm_i(pwm), .cur_i(cur), .temp_i(temp),
    .drv_en_o(drv_en), .chop_o(chop), .ot_fault_o(fault));

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    cur = '0;
    repeat (OFF + 2) tick();
  endtask

  bit hot_m;
  bit above_m;

  initial begin
    #1;
    chk("R1 chop", chop, 0); chk("R1 fault", fault, 0); chk("R1 drv", drv_en, 1);
    pwm = 1'b0; #1; chk("R1 drv low", drv_en, 0);
    repeat (2) tick();
    rst_ni = 1'b1;
    tick();

    // R2: pass-through below limit
    cur = 14'd4000;
    for (int i = 0; i < 8; i++) begin
      pwm = i[0]; #1;
      chk("R2 drv", drv_en, i[0]); chk("R2 chop", chop, 0);
      tick();
    end
    pwm = 1'b1;

    // R6: nominal limit sweep, equality does not trip
    for (int c = 4990; c <= 5010; c += 2) begin
      cur = CUR_W'(c); tick();
      chk("R6 trip", chop, int'(c > NOM));
      settle();
    end

    // R3: exact window length
    cur = 14'd6000; tick();
    cur = '0;
    for (int k = 0; k < OFF; k++) begin
      chk("R3 chop", chop, 1); chk("R3 drv", drv_en, 0);
      tick();
    end
    chk("R3 end", chop, 0); chk("R3 drv back", drv_en, 1);
    settle();

    // R4: over samples during the window are ignored
    cur = 14'd6000; tick();
    cur = 14'd9000;
    for (int k = 0; k < OFF; k++) begin
      chk("R4 chop", chop, 1);
      if (k == OFF - 1) cur = '0;
      tick();
    end
    chk("R4 not extended", chop, 0);
    tick(); chk("R4 no restart", chop, 0);
    settle();

    // R5: still over after the window
    cur = 14'd7000; tick();
    repeat (OFF) tick();
    chk("R5 gap chop", chop, 0); chk("R5 gap drv", drv_en, 1);
    tick();
    chk("R5 retrip", chop, 1);
    settle();

    // R7: hot entry and current sample in the same cycle
    temp = 8'd161; cur = 14'd4500; tick();
    chk("R7 same cycle nominal", chop, 0);
    tick();
    chk("R7 hot limit trips", chop, 1);
    settle();
    temp = 8'd100; tick();
    settle();

    // R8: sweep up then down through the hysteresis band
    hot_m = 1'b0;
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s <= 20; s++) begin
        int t;
        t = (d == 0) ? 148 + s : 168 - s;
        temp = TEMP_W'(t); tick();
        if (t > HOT_C) hot_m = 1'b1;
        else if (t < HOT_C - HYST) hot_m = 1'b0;
        cur = 14'd4500; tick();
        chk("R8 mode", chop, int'(hot_m));
        settle();
      end
    end

    // R9: fault pulse on crossings
    above_m = 1'b0;
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s <= 14; s++) begin
        int t;
        t = (d == 0) ? 168 + s : 182 - s;
        temp = TEMP_W'(t); tick();
        chk("R9 pulse", fault, int'((t > SHUT) && !above_m));
        above_m = (t > SHUT);
      end
    end
    temp = 8'd176; tick(); chk("R9 recross", fault, 1);
    tick(); chk("R9 one cycle", fault, 0);
    temp = 8'd100; tick(); tick();
    settle();

    // R10: fault and trip at the same edge
    temp = 8'd180; cur = 14'd6000; tick();
    chk("R10 fault", fault, 1); chk("R10 chop", chop, 1);
    cur = '0;
    repeat (OFF - 1) tick();
    chk("R10 window held", chop, 1);
    tick(); chk("R10 window end", chop, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule